// File: doc/BRIEF.md
# Postscale Multiplier with Warning-Driven Output Limiting

This block is the last arithmetic stage of a multichannel audio path. Each channel's 24-bit signed sample is multiplied by an 8-bit signed fractional gain. The gain caps the modulation depth that reaches the power stage. Gains use a Q1.7 format, so a gain code `g` means `g/128`, and `-128` means -1.0. A new sample set is taken on every sample-rate tick. The scaled result is registered and marked valid one clock later.

Two active-low protection inputs arrive from the power stage: a thermal warning and an overcurrent warning. While either one is active, a shared limit gain competes with each channel's own gain. When the thermal warning stays active for a programmable number of sample ticks, a fixed gain of about -3 dB (90/128) also joins the competition. Of all the gains in play, the one with the smallest magnitude is applied. The block reports both warnings in active-high form. It also reports whether the timed thermal limit is in force.

Top module: `postscale_limiter`

## Requirements
- R1: On a clock edge where `smp_tick` is high, each channel output is loaded with floor(sample × gain / 128), where sample and gain are two's-complement values. `dout_vld` is high for exactly the following clock cycle. When no tick occurs, the output holds its value.
- R2: A result above 8388607 saturates to 8388607 (the case is -8388608 × -128), and a result below -8388608 saturates to -8388608. It never wraps.
- R3: When neither warning is active and the timed thermal limit is off, channel n uses its own gain, taken from `post_scale[8n+7:8n]`.
- R4: While `therm_warn_n` or `ocur_warn_n` is low, each channel uses whichever of its own gain and `warn_limit` has the smaller magnitude. On equal magnitudes the channel's own gain wins.
- R5: After TICK_LIMIT sample ticks with the synchronized thermal warning continuously active, `hot_limit` goes high. From then on, the gain 90 is also a candidate. On equal magnitudes it loses to both the channel gain and the warning limit.
- R6: Any release of the thermal warning clears the tick count and drops `hot_limit`. A run shorter than TICK_LIMIT ticks never raises it.
- R7: `therm_flag` and `ocur_flag` equal the inverted warning inputs, delayed by a two-flop synchronizer (two clock edges).
- R8: While `rst_n` is low, `dout`, `dout_vld`, `therm_flag`, `ocur_flag` and `hot_limit` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_tick | input | 1 | Sample-rate strobe; the input samples are valid on this cycle |
| din | input | NCH*DW | Packed signed samples, channel 0 in the low bits |
| post_scale | input | NCH*SW | Packed per-channel Q1.7 gains |
| warn_limit | input | SW | Shared Q1.7 limit gain used during warnings |
| therm_warn_n | input | 1 | Thermal warning, active low, asynchronous |
| ocur_warn_n | input | 1 | Overcurrent warning, active low, asynchronous |
| dout | output | NCH*DW | Packed scaled samples |
| dout_vld | output | 1 | High for one cycle after each tick |
| therm_flag | output | 1 | Synchronized thermal warning, active high |
| ocur_flag | output | 1 | Synchronized overcurrent warning, active high |
| hot_limit | output | 1 | Timed thermal limit in force |

## Verification
A wrong selection of gain source shows up as a wrong sample at the output on the very next tick. The bench therefore pairs small limit values with large channel gains and equal-magnitude ties, so that each source produces a different value. A tick counter that is off by one shows up directly on `hot_limit`, which the bench checks after every single tick of a held warning. A counter that fails to clear shows up as a premature `hot_limit` after a release and re-assertion. Saturation errors appear as a sign flip on the one overflowing input pair.

// File: rtl/psl_pkg.sv
package psl_pkg;
  typedef enum logic [1:0] {SRC_POST, SRC_WARN, SRC_HOT} scale_src_e;
  localparam int HOT_GAIN_DEF   = 90;     // 90/128 ~ -3.06 dB
  localparam int TICK_LIMIT_DEF = 38400;  // 400 ms at a 96 kHz tick
endpackage

// File: rtl/psl_warn_mon.sv
module psl_warn_mon #(
  parameter int TICK_LIMIT = psl_pkg::TICK_LIMIT_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic therm_n,
  input  logic ocur_n,
  output logic therm_s,
  output logic ocur_s,
  output logic hot
);
  localparam int CW = $clog2(TICK_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(TICK_LIMIT);

  logic [1:0]    th_q, th_d, oc_q, oc_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    th_d = {th_q[0], ~therm_n};
    oc_d = {oc_q[0], ~ocur_n};
    if (!th_q[1])
      cnt_d = '0;
    else if (tick && (cnt_q != LIM))
      cnt_d = cnt_q + 1'b1;
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      th_q  <= '0;
      oc_q  <= '0;
      cnt_q <= '0;
    end else begin
      th_q  <= th_d;
      oc_q  <= oc_d;
      cnt_q <= cnt_d;
    end
  end

  assign therm_s = th_q[1];
  assign ocur_s  = oc_q[1];
  assign hot     = th_q[1] && (cnt_q == LIM);

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);
  // R6
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !therm_s |=> (cnt_q == '0));
  // R5
  hot_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hot) |-> $past(tick));
endmodule

// File: rtl/psl_scale_sel.sv
module psl_scale_sel #(
  parameter int NCH      = 2,
  parameter int SW       = 8,
  parameter int HOT_GAIN = psl_pkg::HOT_GAIN_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*SW-1:0] post_scale,
  input  logic [SW-1:0]     warn_limit,
  input  logic              warn_any,
  input  logic              hot,
  output logic [NCH*SW-1:0] scale
);
  import psl_pkg::*;
  localparam logic [SW-1:0] HOT_V = SW'(HOT_GAIN);

  function automatic logic [SW:0] mag(input logic [SW-1:0] v);
    return v[SW-1] ? (~{1'b1, v} + (SW+1)'(1)) : {1'b0, v};
  endfunction

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SW-1:0] own, best;
    scale_src_e    src;
    assign own = post_scale[c*SW +: SW];

    always_comb begin
      best = own;
      src  = SRC_POST;
      if (warn_any && (mag(warn_limit) < mag(best))) begin
        best = warn_limit;
        src  = SRC_WARN;
      end
      if (hot && (mag(HOT_V) < mag(best))) begin
        best = HOT_V;
        src  = SRC_HOT;
      end
    end
    assign scale[c*SW +: SW] = best;

    // R4
    no_gain_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mag(scale[c*SW +: SW]) <= mag(own));
    // R3
    quiet_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!warn_any && !hot) |-> (scale[c*SW +: SW] == own));
    // R5
    hot_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_HOT) |-> hot);
  end
endmodule

// File: rtl/psl_chan_mul.sv
module psl_chan_mul #(
  parameter int DW = 24,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] din,
  input  logic [SW-1:0] scale,
  output logic [DW-1:0] dout
);
  localparam int PW = DW + SW;
  localparam logic [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
  localparam logic [SW-1:0] MINS = {1'b1, {(SW-1){1'b0}}};

  logic signed [PW-1:0] prod, shr;
  logic [PW-DW:0]       hi;
  logic                 fits;
  logic [DW-1:0]        res_d, res_q;

  always_comb begin
    prod = $signed(din) * $signed(scale);
    shr  = prod >>> (SW - 1);
    hi   = shr[PW-1:DW-1];
    fits = (&hi) || (~|hi);
    if (fits)
      res_d = shr[DW-1:0];
    else if (shr[PW-1])
      res_d = MINV;
    else
      res_d = MAXV;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      res_q <= '0;
    else if (en)
      res_q <= res_d;
  end

  assign dout = res_q;

  // R2
  sat_corner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && din == MINV && scale == MINS) |=> (dout == MAXV));
  // R1
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(dout));
endmodule

// File: rtl/postscale_limiter.sv
module postscale_limiter #(
  parameter int NCH        = 2,
  parameter int DW         = 24,
  parameter int SW         = 8,
  parameter int TICK_LIMIT = psl_pkg::TICK_LIMIT_DEF,
  parameter int HOT_GAIN   = psl_pkg::HOT_GAIN_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_tick,
  input  logic [NCH*DW-1:0] din,
  input  logic [NCH*SW-1:0] post_scale,
  input  logic [SW-1:0]     warn_limit,
  input  logic              therm_warn_n,
  input  logic              ocur_warn_n,
  output logic [NCH*DW-1:0] dout,
  output logic              dout_vld,
  output logic              therm_flag,
  output logic              ocur_flag,
  output logic              hot_limit
);
  logic [NCH*SW-1:0] scale;
  logic              vld_d, vld_q;

  psl_warn_mon #(.TICK_LIMIT(TICK_LIMIT)) u_mon (
    .clk(clk), .rst_n(rst_n), .tick(smp_tick),
    .therm_n(therm_warn_n), .ocur_n(ocur_warn_n),
    .therm_s(therm_flag), .ocur_s(ocur_flag), .hot(hot_limit)
  );

  psl_scale_sel #(.NCH(NCH), .SW(SW), .HOT_GAIN(HOT_GAIN)) u_sel (
    .clk(clk), .rst_n(rst_n), .post_scale(post_scale),
    .warn_limit(warn_limit), .warn_any(therm_flag | ocur_flag),
    .hot(hot_limit), .scale(scale)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_mul
    psl_chan_mul #(.DW(DW), .SW(SW)) u_mul (
      .clk(clk), .rst_n(rst_n), .en(smp_tick),
      .din(din[c*DW +: DW]), .scale(scale[c*SW +: SW]),
      .dout(dout[c*DW +: DW])
    );
  end

  assign vld_d = smp_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign dout_vld = vld_q;

  // R1
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_vld && !smp_tick) |=> !dout_vld);
  // R5
  hot_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hot_limit |-> therm_flag);
endmodule

// File: tb/sim_postscale_limiter.sv
module sim_postscale_limiter;
  localparam int NCH = 2, DW = 24, SW = 8, L = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              smp_tick = 1'b0;
  logic [NCH*DW-1:0] din = '0;
  logic [NCH*SW-1:0] post_scale = '0;
  logic [SW-1:0]     warn_limit = '0;
  logic              therm_warn_n = 1'b1, ocur_warn_n = 1'b1;
  logic [NCH*DW-1:0] dout;
  logic              dout_vld, therm_flag, ocur_flag, hot_limit;

  int checks = 0, failures = 0, cnt_m = 0;
  bit th = 0, oc = 0, done = 0;

  always #5 clk = ~clk;

  postscale_limiter #(.NCH(NCH), .DW(DW), .SW(SW), .TICK_LIMIT(L)) u0 (
    .clk, .rst_n, .smp_tick, .din, .post_scale, .warn_limit,
    .therm_warn_n, .ocur_warn_n, .dout, .dout_vld,
    .therm_flag, .ocur_flag, .hot_limit
  );

  function automatic int mag(int v); return (v < 0) ? -v : v; endfunction

  function automatic int pick(int own, int lim, bit warn, bit hot);
    int b = own;
    if (warn && mag(lim) < mag(b)) b = lim;
    if (hot && mag(90) < mag(b)) b = 90;
    return b;
  endfunction

  function automatic int scaled(int d, int g);
    longint p = longint'(d) * longint'(g);
    longint r = p >>> 7;
    if (r > 64'sd8388607) r = 8388607;
    if (r < -64'sd8388608) r = -8388608;
    return int'(r);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One tick, check outputs, then apply new warnings and let them settle
  task automatic run_tick(string req, bit nth, bit noc);
    int exp[NCH];
    bit hot_m = (cnt_m == L);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      int d = int'($signed(din[c*DW +: DW]));
      int own = int'($signed(post_scale[c*SW +: SW]));
      int lim = int'($signed(warn_limit));
      exp[c] = scaled(d, pick(own, lim, th | oc, hot_m));
    end
    smp_tick = 1'b1;
    @(negedge clk);
    smp_tick = 1'b0;
    for (int c = 0; c < NCH; c++)
      chk(req, int'($signed(dout[c*DW +: DW])), exp[c]);
    chk("R1 vld", int'(dout_vld), 1);
    if (th) cnt_m = (cnt_m < L) ? cnt_m + 1 : L;
    chk("R5 hot", int'(hot_limit), int'(cnt_m == L));
    th = nth; oc = noc;
    therm_warn_n = ~nth; ocur_warn_n = ~noc;
    if (!th) cnt_m = 0;
    @(negedge clk);
    chk("R1 vld drop", int'(dout_vld), 0);
    @(negedge clk);
    @(negedge clk);
    chk("R7 therm", int'(therm_flag), int'(th));
    chk("R7 ocur", int'(ocur_flag), int'(oc));
    chk("R6 hot", int'(hot_limit), int'(cnt_m == L));
  endtask

  task automatic set_data(int d0, int d1, int g0, int g1, int lim);
    din = {DW'(d1), DW'(d0)};
    post_scale = {SW'(g1), SW'(g0)};
    warn_limit = SW'(lim);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    // R8 reset state
    chk("R8 dout", int'(dout != '0), 0);
    chk("R8 flags", int'({dout_vld, therm_flag, ocur_flag, hot_limit}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 own gain, quiet
    set_data(32'h400000, -1000, 64, -128, 16);
    run_tick("R3 own gain", 0, 0);
    // R2 saturation and exact negative full scale
    set_data(-8388608, -8388608, -128, 127, 127);
    run_tick("R2 saturate", 0, 1);
    // R4 overcurrent: smaller limit wins on both channels
    set_data(3000000, -3000000, 100, -100, 32);
    run_tick("R4 limit wins", 0, 1);
    // R4 larger limit loses, tie keeps own sign
    set_data(3000000, 3000000, 20, -90, 90);
    run_tick("R4 tie own", 1, 0);
    // R5 hold thermal until timeout, checking hot each tick
    set_data(5000000, -5000000, 127, 127, 127);
    for (int i = 0; i < L + 2; i++) run_tick("R5 timed limit", 1, 0);
    // R5 tie: limit 90 and hot 90 -> limit (-90) chosen
    set_data(5000000, 5000000, 127, -100, -90);
    run_tick("R5 tie order", 1, 0);
    // R6 release then short run must not trigger
    run_tick("R6 release", 0, 0);
    for (int i = 0; i < L - 1; i++) run_tick("R6 short run", 1, 0);
    run_tick("R6 brief drop", 0, 0);
    for (int i = 0; i < L - 1; i++) run_tick("R6 rerun", 1, 0);
    run_tick("R6 end", 0, 0);

    // random mix
    for (int i = 0; i < 80; i++) begin
      bit nth = th, noc = oc;
      din = {NCH{24'h0}};
      for (int c = 0; c < NCH; c++) begin
        din[c*DW +: DW] = DW'($urandom);
        post_scale[c*SW +: SW] = SW'($urandom);
      end
      warn_limit = SW'($urandom);
      if (($urandom % 10) == 0) nth = ~th;
      if (($urandom % 6) == 0) noc = ~oc;
      run_tick("R1 random", nth, noc);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule